// File: doc/BRIEF.md
# Real-Time Calendar Counter

This block keeps wall-clock time and date for a low-power timekeeping subsystem. A 64 Hz enable pulse, already synchronous to the system clock, feeds a six-stage binary prescaler. The prescaler emits one increment per second, and that increment ripples through packed-BCD seconds, minutes, hours, day of month, month and two-digit year. The chain also advances a binary day-of-week counter and toggles a century bit whenever the year wraps.

A host reaches every field through a simple register port. On the write side, any field can be loaded directly, and the low-supply flag can be cleared. On the read side, an address selects one field for a combinational read. A halt input holds the prescaler at zero so that a test or a time set starts from a known phase. A freeze input holds all calendar fields still while the host reads a multi-byte snapshot. A second that elapses during a freeze, or during a write cycle, is held and applied as soon as the fields are free again.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset, seconds, minutes, hours, weekday and year read 0, and day and month read 01. The century bit and the low-supply flag read 0, and address 7 reads 0.
- R2: Seconds and minutes count 00 to 59 in packed BCD, and hours count 00 to 23. Each field wraps to 00 and carries into the next field.
- R3: Day of month runs from 01 and wraps to 01 after its last day. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. Month 12 wraps to 01 and advances the year.
- R4: February ends on day 29 when the year value is a multiple of 4, with year 00 counted as a multiple of 4. Otherwise February ends on day 28.
- R5: When the year wraps from 99 to 00, the century bit toggles. The century bit is bit 7 of the month register (address 5).
- R6: The weekday (address 4, bits 2:0) is plain binary. It advances by one on every day change and wraps from 6 to 0.
- R7: While halt is high, the prescaler is held at zero and no second elapses. After halt falls, the first second elapses on the 32nd tick, and each later second elapses 64 ticks after the one before.
- R8: While freeze is high, no calendar field changes. One second that elapses during a freeze is applied exactly once, on the cycle after freeze falls.
- R9: The low-supply flag is bit 7 of the seconds register (address 0). A high vlow_in sets the flag in the next cycle, and the flag stays set. Writing the seconds register with bit 7 at 0 clears the flag; writing it with bit 7 at 1 leaves the flag unchanged.
- R10: A write loads a field on the next clock edge. The field addresses are: 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month with the century bit in bit 7, and 6 year.
- R11: A second that elapses in a write cycle is not lost. It is applied on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_64 | input | 1 | One-cycle 64 Hz enable |
| halt | input | 1 | Holds the prescaler at zero |
| freeze | input | 1 | Holds calendar fields during a host read |
| vlow_in | input | 1 | Low-supply indication, sets the sticky flag |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write field address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read field address |
| rd_data | output | 8 | Selected field, combinational |

## Verification
The bench targets the rollover boundaries:
- End of a 30-day month versus a 31-day month. A wrong month-length table would produce a 31st of April, or skip from the 30th of May straight to June.
- Leap February in year 00, 12, 24 and 96, and non-leap February in year 10 and 23. A rule that looks only at the ones digit, or that excludes year 00, would stop February one day early or one day late.
- Year wrap in both directions of the century bit, and the weekday wrap from 6 to 0.
- The 32-tick first second after a halt. A prescaler that resumed at full phase would be 32 ticks late.
- A second landing inside a freeze, or in the same cycle as a write. A design that drops it would lose a second; one that replays every missed pulse would jump ahead by two.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DAY   = 3'd3,
        FLD_WDAY  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6
    } fld_addr_e;

    typedef struct packed {
        logic        cent;
        logic [7:0]  yr;
        logic [7:0]  mon;
        logic [2:0]  wday;
        logic [7:0]  day;
        logic [7:0]  hr;
        logic [7:0]  min;
        logic [7:0]  sec;
    } cal_t;

    localparam logic [7:0] SEC_TOP  = 8'h59;
    localparam logic [7:0] MIN_TOP  = 8'h59;
    localparam logic [7:0] HR_TOP   = 8'h23;
    localparam logic [7:0] MON_TOP  = 8'h12;
    localparam logic [7:0] YR_TOP   = 8'h99;
    localparam logic [2:0] WDAY_TOP = 3'd6;
    localparam logic [7:0] ONE_BCD  = 8'h01;

    localparam cal_t CAL_RESET = '{cent: 1'b0, yr: 8'h00, mon: ONE_BCD,
                                   wday: 3'd0, day: ONE_BCD, hr: 8'h00,
                                   min: 8'h00, sec: 8'h00};

    // Add one to a packed two-digit BCD value (caller handles the wrap).
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return v + 8'h01;
    endfunction

    // Multiple of four for a BCD year: bit 4 is the tens parity.
    function automatic logic leap_year(input logic [4:0] y);
        if (y[4])
            return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
        else
            return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [4:0] y);
        case (mon)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int STAGES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic halt,
    output logic sec_pulse
);
    // Fires on the tick that moves the count into its upper half, so the
    // first second after a halt comes half a period early.
    localparam logic [STAGES-1:0] FIRE = {1'b0, {(STAGES-1){1'b1}}};

    logic [STAGES-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || halt)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign sec_pulse = tick && !halt && (cnt_q == FIRE);
endmodule

// File: rtl/rtc_advance_gate.sv
module rtc_advance_gate (
    input  logic clk,
    input  logic rst,
    input  logic sec_pulse,
    input  logic freeze,
    input  logic wr_en,
    output logic adv,
    output logic pend_q
);
    logic blocked;

    assign blocked = freeze || wr_en;
    assign adv     = !blocked && (sec_pulse || pend_q);

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (blocked)
            pend_q <= pend_q || sec_pulse;
        else
            pend_q <= pend_q && sec_pulse;
    end
endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vlow_in,
    output cal_t              cal_q,
    output logic              vl_q
);
    cal_t       nxt;
    logic       s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap, y_wrap;
    logic [7:0] last_day;

    always_comb begin
        last_day = month_last_day(cal_q.mon, cal_q.yr[4:0]);
        s_wrap   = (cal_q.sec == SEC_TOP);
        m_wrap   = s_wrap  && (cal_q.min == MIN_TOP);
        h_wrap   = m_wrap  && (cal_q.hr  == HR_TOP);
        d_wrap   = h_wrap  && (cal_q.day == last_day);
        mo_wrap  = d_wrap  && (cal_q.mon == MON_TOP);
        y_wrap   = mo_wrap && (cal_q.yr  == YR_TOP);

        nxt     = cal_q;
        nxt.sec = s_wrap ? 8'h00 : bcd_next(cal_q.sec);
        if (s_wrap)
            nxt.min = (cal_q.min == MIN_TOP) ? 8'h00 : bcd_next(cal_q.min);
        if (m_wrap)
            nxt.hr = (cal_q.hr == HR_TOP) ? 8'h00 : bcd_next(cal_q.hr);
        if (h_wrap) begin
            nxt.day  = d_wrap ? ONE_BCD : bcd_next(cal_q.day);
            nxt.wday = (cal_q.wday == WDAY_TOP) ? 3'd0 : cal_q.wday + 3'd1;
        end
        if (d_wrap)
            nxt.mon = mo_wrap ? ONE_BCD : bcd_next(cal_q.mon);
        if (mo_wrap)
            nxt.yr = y_wrap ? 8'h00 : bcd_next(cal_q.yr);
        if (y_wrap)
            nxt.cent = ~cal_q.cent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= CAL_RESET;
            vl_q  <= 1'b0;
        end else begin
            if (vlow_in)
                vl_q <= 1'b1;
            else if (wr_en && (wr_addr == FLD_SEC) && !wr_data[7])
                vl_q <= 1'b0;

            if (wr_en) begin
                case (wr_addr)
                    FLD_SEC:   cal_q.sec  <= {1'b0, wr_data[6:0]};
                    FLD_MIN:   cal_q.min  <= {1'b0, wr_data[6:0]};
                    FLD_HOUR:  cal_q.hr   <= {2'b00, wr_data[5:0]};
                    FLD_DAY:   cal_q.day  <= {2'b00, wr_data[5:0]};
                    FLD_WDAY:  cal_q.wday <= wr_data[2:0];
                    FLD_MONTH: begin
                        cal_q.mon  <= {3'b000, wr_data[4:0]};
                        cal_q.cent <= wr_data[7];
                    end
                    FLD_YEAR:  cal_q.yr   <= wr_data;
                    default: ;
                endcase
            end else if (adv) begin
                cal_q <= nxt;
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int PRESCALE_STAGES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_64,
    input  logic              halt,
    input  logic              freeze,
    input  logic              vlow_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic sec_pulse;
    logic adv;
    logic pend_q;
    logic vl_q;
    cal_t cal_q;

    rtc_prescaler #(.STAGES(PRESCALE_STAGES)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_64),
        .halt      (halt),
        .sec_pulse (sec_pulse)
    );

    rtc_advance_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .sec_pulse (sec_pulse),
        .freeze    (freeze),
        .wr_en     (wr_en),
        .adv       (adv),
        .pend_q    (pend_q)
    );

    rtc_calendar_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .vlow_in (vlow_in),
        .cal_q   (cal_q),
        .vl_q    (vl_q)
    );

    always_comb begin
        case (rd_addr)
            FLD_SEC:   rd_data = cal_q.sec | {vl_q, 7'b0};
            FLD_MIN:   rd_data = cal_q.min;
            FLD_HOUR:  rd_data = cal_q.hr;
            FLD_DAY:   rd_data = cal_q.day;
            FLD_WDAY:  rd_data = {5'b0, cal_q.wday};
            FLD_MONTH: rd_data = cal_q.mon | {cal_q.cent, 7'b0};
            FLD_YEAR:  rd_data = cal_q.yr;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_sva.sv
module rtc_calendar_sva
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              halt,
    input logic              freeze,
    input logic              vlow_in,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              sec_pulse,
    input logic              pend_q,
    input logic              vl_q,
    input cal_t              cal_q
);
    assert_time_range_R2: assert property (@(posedge clk) disable iff (rst)
        (cal_q.sec <= 8'h59) && (cal_q.min <= 8'h59) && (cal_q.hr <= 8'h23));

    assert_wday_range_R6: assert property (@(posedge clk) disable iff (rst)
        cal_q.wday <= 3'd6);

    assert_century_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cal_q.cent) && !$past(wr_en))
            |-> ($past(cal_q.yr) == 8'h99) && (cal_q.yr == 8'h00));

    assert_halt_no_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        halt |-> !sec_pulse);

    assert_freeze_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (freeze && !wr_en) |=> $stable(cal_q));

    assert_freeze_remember_R8: assert property (@(posedge clk) disable iff (rst)
        (sec_pulse && freeze) |=> pend_q);

    assert_vl_set_R9: assert property (@(posedge clk) disable iff (rst)
        vlow_in |=> vl_q);

    assert_vl_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (vl_q && !(wr_en && (wr_addr == FLD_SEC))) |=> vl_q);

    assert_write_defers_R11: assert property (@(posedge clk) disable iff (rst)
        (sec_pulse && wr_en) |=> pend_q);
endmodule

bind rtc_calendar_core rtc_calendar_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .freeze    (freeze),
    .vlow_in   (vlow_in),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .sec_pulse (sec_pulse),
    .pend_q    (pend_q),
    .vl_q      (vl_q),
    .cal_q     (cal_q)
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_64 = 1'b0;
    logic       halt = 1'b0;
    logic       freeze = 1'b0;
    logic       vlow_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rtc_calendar_core dut (
        .clk(clk), .rst(rst), .tick_64(tick_64), .halt(halt),
        .freeze(freeze), .vlow_in(vlow_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    // Fields packed as {sec, min, hour, day, wday, month, year}; input then expected.
    localparam logic [111:0] VEC [18] = '{
        {56'h00_00_00_01_00_01_00, 56'h01_00_00_01_00_01_00},
        {56'h59_34_12_10_03_07_42, 56'h00_35_12_10_03_07_42},
        {56'h59_59_09_10_03_07_42, 56'h00_00_10_10_03_07_42},
        {56'h59_59_23_15_06_03_21, 56'h00_00_00_16_00_03_21},
        {56'h59_59_23_30_02_04_21, 56'h00_00_00_01_03_05_21},
        {56'h59_59_23_31_04_05_21, 56'h00_00_00_01_05_06_21},
        {56'h59_59_23_28_01_02_23, 56'h00_00_00_01_02_03_23},
        {56'h59_59_23_28_01_02_24, 56'h00_00_00_29_02_02_24},
        {56'h59_59_23_29_05_02_00, 56'h00_00_00_01_06_03_00},
        {56'h59_59_23_28_05_02_00, 56'h00_00_00_29_06_02_00},
        {56'h59_59_23_31_03_12_99, 56'h00_00_00_01_04_81_00},
        {56'h59_59_23_31_03_92_99, 56'h00_00_00_01_04_01_00},
        {56'h59_59_23_30_00_11_09, 56'h00_00_00_01_01_12_09},
        {56'h59_59_23_30_00_09_19, 56'h00_00_00_01_01_10_19},
        {56'h59_59_23_30_06_06_76, 56'h00_00_00_01_00_07_76},
        {56'h59_59_23_29_02_02_96, 56'h00_00_00_01_03_03_96},
        {56'h59_59_23_28_02_02_10, 56'h00_00_00_01_03_03_10},
        {56'h59_59_23_28_02_02_12, 56'h00_00_00_29_03_02_12}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2:            return "R2";
            3, 14:              return "R6";
            4, 5, 12, 13:       return "R3";
            10, 11:             return "R5";
            default:            return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic read_all(output logic [55:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < 7; i++) begin
            rd(3'(i), b);
            v = {v[47:0], b};
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            tick_64 = 1'b1;
        end
        @(negedge clk);
        tick_64 = 1'b0;
    endtask

    task automatic load_time(input logic [55:0] t);
        halt = 1'b1;
        for (int i = 0; i < 7; i++)
            wr(3'(i), t[55 - 8*i -: 8]);
        @(negedge clk);
        halt = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [55:0] snap;
        logic [7:0]  b;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        read_all(snap);
        check("R1", 64'(snap), 64'h00_00_00_01_00_01_00);
        rd(3'd7, b);
        check("R1", 64'(b), 64'h0);

        // R10 direct load, century bit through month register
        wr(3'd5, 8'h92);
        rd(3'd5, b);
        check("R10", 64'(b), 64'h92);
        wr(3'd4, 8'h05);
        rd(3'd4, b);
        check("R10", 64'(b), 64'h05);

        // Vector table: load, one second, compare
        for (int i = 0; i < 18; i++) begin
            load_time(VEC[i][111:56]);
            ticks(32);
            read_all(snap);
            check(vec_tag(i), 64'(snap), 64'(VEC[i][55:0]));
        end

        // R7 prescaler phase after halt
        load_time(56'h10_00_00_01_00_01_00);
        ticks(31);
        rd(3'd0, b); check("R7", 64'(b), 64'h10);
        ticks(1);
        rd(3'd0, b); check("R7", 64'(b), 64'h11);
        ticks(63);
        rd(3'd0, b); check("R7", 64'(b), 64'h11);
        ticks(1);
        rd(3'd0, b); check("R7", 64'(b), 64'h12);
        ticks(20);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        ticks(31);
        rd(3'd0, b); check("R7", 64'(b), 64'h12);
        ticks(1);
        rd(3'd0, b); check("R7", 64'(b), 64'h13);

        // R8 freeze holds, then applies one second
        load_time(56'h20_00_00_01_00_01_00);
        freeze = 1'b1;
        ticks(32);
        rd(3'd0, b); check("R8", 64'(b), 64'h20);
        ticks(10);
        rd(3'd0, b); check("R8", 64'(b), 64'h20);
        freeze = 1'b0;
        @(negedge clk);
        rd(3'd0, b); check("R8", 64'(b), 64'h21);
        @(negedge clk);
        rd(3'd0, b); check("R8", 64'(b), 64'h21);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        freeze = 1'b1;
        ticks(96);
        freeze = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd0, b); check("R8", 64'(b), 64'h22);

        // R11 second coinciding with a write
        load_time(56'h30_00_00_01_00_01_00);
        ticks(31);
        @(negedge clk);
        tick_64 = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h22;
        @(negedge clk);
        tick_64 = 1'b0; wr_en = 1'b0;
        rd(3'd0, b); check("R11", 64'(b), 64'h30);
        rd(3'd1, b); check("R11", 64'(b), 64'h22);
        @(negedge clk);
        rd(3'd0, b); check("R11", 64'(b), 64'h31);

        // R9 low-supply flag
        rd(3'd0, b); check("R9", 64'(b[7]), 64'h0);
        vlow_in = 1'b1;
        @(negedge clk);
        vlow_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(3'd0, b); check("R9", 64'(b[7]), 64'h1);
        wr(3'd0, 8'h85);
        rd(3'd0, b); check("R9", 64'(b), 64'h85);
        wr(3'd0, 8'h05);
        rd(3'd0, b); check("R9", 64'(b), 64'h05);
        wr(3'd0, 8'h86);
        rd(3'd0, b); check("R9", 64'(b), 64'h06);

        summary();
        $finish;
    end
endmodule